// File: doc/BRIEF.md
# Bidirectional Two-Bank Multiplexing Latch

This block links one shared 12-bit port, A, to two 12-bit bank ports, B1 and B2, and moves address or data words in either direction. Going from A toward the banks it splits one stream into two: A feeds two separate hold latches, one per bank, and each bank port drives the word its own latch keeps. Going from the banks toward A it merges: each bank port feeds its own hold latch, and a source-select input decides which of those two latched words appears on A.

Every port is modelled as three separate vectors: an input, an output and an output-drive flag. No tri-state nets are used. Each port has its own active-low drive control. The four hold latches work in the synchronous domain of `clk`. A latch is transparent while its load input is high, so its output follows its input within the same cycle, and on every rising edge where the load is high it also stores that input. Once the load is low, the output shows the word stored at the last such edge. All control pins are plain levels. No stream handshake is applied, because every word is held by level control and nothing is queued, so there is no back-pressure to express. An active-low asynchronous reset clears all four latches.

Top module: `bank_mux_latch`

## Requirements
- R1: While `rst_n` is low, all four latches hold zero. With every load input low and every drive control low, `a_out`, `b1_out` and `b2_out` then read zero.
- R2: While a load input is high, the output of its latch equals that latch's input in the same cycle, with no clock edge in between.
- R3: After a load input falls, its latch output equals the input value sampled at the last rising edge of `clk` where the load was high. It keeps that value until the load goes high again.
- R4: `ld_ab1` loads `a_in` into the B1-side latch and `ld_ab2` loads `a_in` into the B2-side latch, so the two banks can hold different words taken from A.
- R5: `ld_ba1` loads `b1_in` into one latch and `ld_ba2` loads `b2_in` into another, and each load works independently of the other.
- R6: When `src_b1` is 1, A carries the B1-side inbound latch. When `src_b1` is 0, A carries the B2-side inbound latch.
- R7: `a_drv_n` is active low. When it is 1, `a_oe` is 0 and `a_out` is all zeros. When it is 0, `a_oe` is 1.
- R8: `b1_drv_n` and `b2_drv_n` are independent active-low controls, and all four combinations are legal. A bank whose control is 1 shows `oe` 0 and an all-zero output. A bank whose control is 0 shows `oe` 1 and its latched word.
- R9: While a bank's outbound load is low, changes on `a_in` do not change that bank's output.
- R10: No port echoes itself. `a_out` never depends on `a_in`, and `b1_out` and `b2_out` never depend on `b1_in` or `b2_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch capture |
| rst_n | input | 1 | Asynchronous active-low reset, clears all latches |
| a_in | input | 12 | Word arriving on shared port A |
| a_out | output | 12 | Word driven onto port A (zero when not driven) |
| a_oe | output | 1 | High when port A is driven |
| b1_in | input | 12 | Word arriving on bank port B1 |
| b1_out | output | 12 | Word driven onto B1 (zero when not driven) |
| b1_oe | output | 1 | High when B1 is driven |
| b2_in | input | 12 | Word arriving on bank port B2 |
| b2_out | output | 12 | Word driven onto B2 (zero when not driven) |
| b2_oe | output | 1 | High when B2 is driven |
| ld_ab1 | input | 1 | Load/transparent control, A into B1-side latch |
| ld_ab2 | input | 1 | Load/transparent control, A into B2-side latch |
| ld_ba1 | input | 1 | Load/transparent control, B1 into its inbound latch |
| ld_ba2 | input | 1 | Load/transparent control, B2 into its inbound latch |
| src_b1 | input | 1 | 1 selects the B1-side inbound latch for A, 0 selects B2-side |
| a_drv_n | input | 1 | Active-low drive control for A |
| b1_drv_n | input | 1 | Active-low drive control for B1 |
| b2_drv_n | input | 1 | Active-low drive control for B2 |

## Verification
Some properties are checked on every cycle. Each latch holds steady while its load stays low, and it keeps the word sampled at the edge where the load fell. A bank output stays put while its load and drive control are both steady low. Port A stays put while both inbound loads and its select and drive are quiet, whatever `a_in` does. A disabled A port shows a zero word and a low drive flag. Other behaviour shows only in the bench scenarios. These include same-cycle transparency and the two banks capturing different words from A. They also include the source select swapping A between two held words and all four bank-enable combinations.

// File: rtl/bml_pkg.sv
package bml_pkg;
  localparam int NUM_BANKS = 2;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  typedef enum logic {
    SRC_BANK2 = 1'b0,
    SRC_BANK1 = 1'b1
  } a_src_e;
endpackage

// File: rtl/bml_hold_latch.sv
module bml_hold_latch #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= d;
  end

  // transparent while loading, stored word otherwise
  assign q = load ? d : held;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load)) |-> $stable(q));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load) && $past(rst_n)) |-> (q == $past(d)));
endmodule

// File: rtl/bml_port_drive.sv
module bml_port_drive #(
  parameter int WIDTH = 12
) (
  input  logic             drv_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] pad_out,
  output logic             pad_oe
);
  assign pad_oe  = ~drv_n;
  assign pad_out = drv_n ? '0 : word;
endmodule

// File: rtl/bank_mux_latch.sv
module bank_mux_latch
  import bml_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b1_in,
  output logic [WIDTH-1:0] b1_out,
  output logic             b1_oe,
  input  logic [WIDTH-1:0] b2_in,
  output logic [WIDTH-1:0] b2_out,
  output logic             b2_oe,
  input  logic             ld_ab1,
  input  logic             ld_ab2,
  input  logic             ld_ba1,
  input  logic             ld_ba2,
  input  logic             src_b1,
  input  logic             a_drv_n,
  input  logic             b1_drv_n,
  input  logic             b2_drv_n
);
  logic [NUM_BANKS-1:0] ld_out_v, ld_in_v, drv_n_v, oe_v;
  logic [WIDTH-1:0]     bank_in  [NUM_BANKS];
  logic [WIDTH-1:0]     out_q    [NUM_BANKS];
  logic [WIDTH-1:0]     in_q     [NUM_BANKS];
  logic [WIDTH-1:0]     bank_out [NUM_BANKS];
  logic [WIDTH-1:0]     a_word;
  a_src_e               a_src;

  assign ld_out_v   = {ld_ab2, ld_ab1};
  assign ld_in_v    = {ld_ba2, ld_ba1};
  assign drv_n_v    = {b2_drv_n, b1_drv_n};
  assign bank_in[0] = b1_in;
  assign bank_in[1] = b2_in;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    // outbound: shared A into this bank
    bml_hold_latch #(.WIDTH(WIDTH)) u_out_latch (
      .clk(clk), .rst_n(rst_n), .load(ld_out_v[g]), .d(a_in), .q(out_q[g]));
    // inbound: this bank toward A
    bml_hold_latch #(.WIDTH(WIDTH)) u_in_latch (
      .clk(clk), .rst_n(rst_n), .load(ld_in_v[g]), .d(bank_in[g]), .q(in_q[g]));
    bml_port_drive #(.WIDTH(WIDTH)) u_drive (
      .drv_n(drv_n_v[g]), .word(out_q[g]), .pad_out(bank_out[g]), .pad_oe(oe_v[g]));
  end

  assign a_src  = a_src_e'(src_b1);
  assign a_word = (a_src == SRC_BANK1) ? in_q[0] : in_q[1];

  bml_port_drive #(.WIDTH(WIDTH)) u_a_drive (
    .drv_n(a_drv_n), .word(a_word), .pad_out(a_out), .pad_oe(a_oe));

  assign b1_out = bank_out[0];
  assign b1_oe  = oe_v[0];
  assign b2_out = bank_out[1];
  assign b2_oe  = oe_v[1];

  p_b1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ab1 && $past(!ld_ab1) && $stable(b1_drv_n)) |-> $stable(b1_out));

  p_b2_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ab2 && $past(!ld_ab2) && $stable(b2_drv_n)) |-> $stable(b2_out));

  p_a_no_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ba1 && !ld_ba2 && $past(!ld_ba1) && $past(!ld_ba2)
     && $stable(src_b1) && $stable(a_drv_n)) |-> $stable(a_out));

  p_a_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_drv_n |-> (!a_oe && a_out == '0));
endmodule

// File: tb/bank_mux_latch_test.sv
`timescale 1ns/1ps
module bank_mux_latch_test;
  localparam int W = 12;

  typedef struct {
    string        tag;
    logic         a_oe, b1_oe, b2_oe;
    logic [W-1:0] a_out, b1_out, b2_out;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic ld_ab1 = 0, ld_ab2 = 0, ld_ba1 = 0, ld_ba2 = 0, src_b1 = 0;
  logic a_drv_n = 0, b1_drv_n = 0, b2_drv_n = 0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  logic [W-1:0] m_ab1 = '0, m_ab2 = '0, m_ba1 = '0, m_ba2 = '0;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_mux_latch #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
    .ld_ab1(ld_ab1), .ld_ab2(ld_ab2), .ld_ba1(ld_ba1), .ld_ba2(ld_ba2),
    .src_b1(src_b1), .a_drv_n(a_drv_n), .b1_drv_n(b1_drv_n), .b2_drv_n(b2_drv_n));

  // driver: applies one cycle of stimulus and queues the expected port values
  task automatic step(string tag, logic [W-1:0] ai, logic [W-1:0] b1i, logic [W-1:0] b2i,
                      logic lab1, logic lab2, logic lba1, logic lba2, logic s,
                      logic adn, logic b1dn, logic b2dn);
    exp_t e;
    logic [W-1:0] q1, q2, r1, r2;
    @(posedge clk);
    if (rst_n) begin
      if (ld_ab1) m_ab1 = a_in;
      if (ld_ab2) m_ab2 = a_in;
      if (ld_ba1) m_ba1 = b1_in;
      if (ld_ba2) m_ba2 = b2_in;
    end
    #3;
    a_in = ai; b1_in = b1i; b2_in = b2i;
    ld_ab1 = lab1; ld_ab2 = lab2; ld_ba1 = lba1; ld_ba2 = lba2;
    src_b1 = s; a_drv_n = adn; b1_drv_n = b1dn; b2_drv_n = b2dn;
    q1 = lab1 ? ai : m_ab1;
    q2 = lab2 ? ai : m_ab2;
    r1 = lba1 ? b1i : m_ba1;
    r2 = lba2 ? b2i : m_ba2;
    e.tag    = tag;
    e.a_oe   = !adn;
    e.a_out  = adn ? '0 : (s ? r1 : r2);
    e.b1_oe  = !b1dn;
    e.b1_out = b1dn ? '0 : q1;
    e.b2_oe  = !b2dn;
    e.b2_out = b2dn ? '0 : q2;
    sb.push_back(e);
  endtask

  // monitor: compares at the falling edge, away from capture
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (a_oe !== e.a_oe || a_out !== e.a_out || b1_oe !== e.b1_oe ||
            b1_out !== e.b1_out || b2_oe !== e.b2_oe || b2_out !== e.b2_out) begin
          fails++;
          $display("FAIL %s: got a=%b/%h b1=%b/%h b2=%b/%h exp a=%b/%h b1=%b/%h b2=%b/%h",
                   e.tag, a_oe, a_out, b1_oe, b1_out, b2_oe, b2_out,
                   e.a_oe, e.a_out, e.b1_oe, e.b1_out, e.b2_oe, e.b2_out);
        end
      end
    end
  end

  initial begin
    // R1: reset state
    step("R1 reset clears", 12'h5A5, 12'h3C3, 12'h0F0, 0,0,0,0, 1, 0,0,0);
    @(negedge clk); #1 rst_n = 1;
    // R2 / R4: B1 bank transparent
    step("R2 R4 b1 transparent", 12'h123, 12'h000, 12'h000, 1,0,0,0, 1, 1,0,0);
    // R3 / R9: b1 holds, a_in changes
    step("R3 R9 b1 holds", 12'hABC, 12'h000, 12'h000, 0,0,0,0, 1, 1,0,0);
    // R4: b2 captures different word
    step("R4 b2 transparent", 12'h456, 12'h000, 12'h000, 0,1,0,0, 1, 1,0,0);
    step("R4 R9 both banks hold", 12'hFFF, 12'h000, 12'h000, 0,0,0,0, 1, 1,0,0);
    // R5 / R6 / R2: inbound latches open
    step("R5 R6 inbound open sel b1", 12'h000, 12'h321, 12'h654, 0,0,1,1, 1, 0,0,0);
    step("R3 R5 inbound held sel b1", 12'h777, 12'h000, 12'h000, 0,0,0,0, 1, 0,0,0);
    step("R6 sel b2", 12'h777, 12'h111, 12'h222, 0,0,0,0, 0, 0,0,0);
    // R5: load only B1 side
    step("R5 b1 side only", 12'h777, 12'h9AB, 12'hDEF, 0,0,1,0, 0, 0,0,0);
    step("R5 R6 b1 side kept", 12'h777, 12'h000, 12'h000, 0,0,0,0, 1, 0,0,0);
    // R7: A disabled
    step("R7 a disabled", 12'h777, 12'h000, 12'h000, 0,0,0,0, 1, 1,0,0);
    // R8: four bank enable combos
    step("R8 both off", 12'h000, 12'h000, 12'h000, 0,0,0,0, 1, 0,1,1);
    step("R8 b1 only", 12'h000, 12'h000, 12'h000, 0,0,0,0, 1, 0,0,1);
    step("R8 b2 only", 12'h000, 12'h000, 12'h000, 0,0,0,0, 1, 0,1,0);
    step("R8 both on", 12'h000, 12'h000, 12'h000, 0,0,0,0, 1, 0,0,0);
    // R10: no echo with inbound open, outbound closed
    step("R10 b inputs do not echo", 12'h0AA, 12'h0BB, 12'h0CC, 0,0,1,1, 1, 0,0,0);
    step("R10 a input does not echo", 12'hEEE, 12'h0BB, 12'h0CC, 0,0,0,0, 0, 0,0,0);
    // R3: reopen and close bank1 with new word
    step("R2 b1 reopened", 12'h842, 12'h000, 12'h000, 1,0,0,0, 0, 0,0,0);
    step("R3 b1 new hold", 12'h000, 12'h000, 12'h000, 0,0,0,0, 0, 0,0,0);
    @(negedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule